// File: doc/BRIEF.md
# Zero-Suppressing Hit Concentrator

The block takes in eight serial readout lanes. Each lane carries a chain of front-end chips that are read out one after another. For every channel a chip sends a header word and then up to four time/amplitude sample pairs. The block compares each amplitude with a programmable threshold. Samples at or below the threshold are dropped. Each surviving sample becomes one 64-bit hit record, tagged with lane, chip, channel, sample slot and the low bits of the train number.

Records from the lanes are collected by a round-robin arbiter into a small record FIFO. They leave as bytes on a valid/ready stream. The serial side cannot be stalled, so a record that finds the FIFO full is discarded. The loss is recorded in a sticky overflow flag and a saturating counter. A train-start pulse restarts the readout position of every lane and latches the new train number.

Top module: `hitConcentrator`

## Requirements
- R1: Each lane shifts in 13-bit words, most significant bit first, one bit per clock in which its strobe is high. A channel is 9 words: word 0 is a header whose content is ignored, then time and amplitude words alternate for samples 0, 1, 2 and 3.
- R2: Within a lane, channels run from 0 to NUM_CHANNELS-1 inside a chip, and chips run from 0 to NUM_CHIPS-1. After the last channel of the last chip, the lane ignores all bits until the next train-start pulse. That pulse restarts the lane at chip 0, channel 0, word 0 and latches trainNum.
- R3: A sample produces a record only when its amplitude is strictly greater than threshold. Equal or smaller amplitudes produce nothing.
- R4: The record layout is as follows. Bits 63:51 hold train number bits 12:0. Bits 50:48 hold the lane, 47:44 the chip, 43:34 the channel and 33:32 the sample slot. Bits 31:16 hold the time word zero-extended, and bits 15:0 hold the amplitude zero-extended.
- R5: A record leaves as 8 bytes, bits 63:56 first and bits 7:0 last, one byte per cycle in which outValid and outReady are both high.
- R6: While outValid is high and outReady is low, outValid stays high and outData does not change.
- R7: Records from any one lane leave in the order their samples arrived.
- R8: Without overflow, the number of records equals the number of above-threshold samples, with no duplicates and no extras.
- R9: A record that finds the FIFO full is discarded. It sets overflow, which stays set until reset, and it increments lostCount. Records already stored still leave intact.
- R10: After reset, outValid, overflow and lostCount are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| threshold | input | 13 | Amplitude threshold, strict greater-than |
| trainStart | input | 1 | One-cycle pulse restarting all lanes |
| trainNum | input | 16 | Train number, latched on trainStart |
| serBit | input | 8 | Serial data bit per lane |
| serStrobe | input | 8 | Bit-valid strobe per lane |
| outData | output | 8 | Record byte |
| outValid | output | 1 | Byte available |
| outReady | input | 1 | Downstream accepts the byte |
| overflow | output | 1 | Sticky record-loss flag |
| lostCount | output | 16 | Saturating count of dropped records |

## Verification
All eight lanes are driven with a small chip and channel configuration. The amplitudes are placed at zero, threshold minus one, threshold, threshold plus one, full scale and well above threshold, so the strict comparison is separated from a greater-or-equal one. The threshold is swept across three trains: a mid value, zero (every nonzero sample is kept) and full scale (nothing is kept). Train numbers with their upper bits set show that the tag is truncated correctly.

Extra words sent after the last chip show whether the lane stops at the end of readout. Random-looking headers show that header content is ignored. A fourth train with the output stalled fills the FIFO, which shows that exactly the FIFO depth of records survive and that the remainder is counted as lost.

// File: rtl/hcPkg.sv
package hcPkg;
  localparam int LANES        = 8;
  localparam int LANE_W       = $clog2(LANES);
  localparam int WORD_W       = 13;
  localparam int SAMPLES      = 4;
  localparam int WORDS_PER_CH = 1 + 2 * SAMPLES;
  localparam int TRAIN_W      = 13;
  localparam int BYTES_PER_REC = 8;

  typedef struct packed {
    logic [TRAIN_W-1:0] trainLow;
    logic [LANE_W-1:0]  lane;
    logic [3:0]         chip;
    logic [9:0]         chan;
    logic [1:0]         sample;
    logic [15:0]        sampleTime;
    logic [15:0]        adc;
  } hitRec_t;

  typedef struct packed {
    logic [LANES-1:0] grant;
    logic             push;
    logic             drop;
    logic             pop;
    logic [2:0]       byteIdx;
  } ctrlStrobe_t;
endpackage

// File: rtl/hcLaneFront.sv
module hcLaneFront
  import hcPkg::*;
#(
  parameter int NUM_CHIPS    = 12,
  parameter int NUM_CHANNELS = 1024,
  parameter logic [LANE_W-1:0] LANE_ID = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serBit,
  input  logic               serStrobe,
  input  logic               trainStart,
  input  logic [TRAIN_W-1:0] trainLow,
  input  logic [WORD_W-1:0]  threshold,
  input  logic               grant,
  output logic               pendValid,
  output hitRec_t            pendRec
);
  logic [WORD_W-2:0] shiftReg;
  logic [3:0]        bitCnt;
  logic [3:0]        wordIdx;
  logic [9:0]        chanCnt;
  logic [3:0]        chipCnt;
  logic              laneDone;
  logic [WORD_W-1:0] timeReg;

  logic              wordDone, isTime, isAmp, hitNow;
  logic [WORD_W-1:0] word;
  logic [3:0]        halfIdx;
  logic [1:0]        sampleIdx;

  always_comb begin
    wordDone  = serStrobe && !laneDone && !trainStart && (bitCnt == 4'(WORD_W - 1));
    word      = {shiftReg, serBit};
    isTime    = wordIdx[0];
    isAmp     = (wordIdx != 4'd0) && !wordIdx[0];
    hitNow    = wordDone && isAmp && (word > threshold);
    halfIdx   = wordIdx >> 1;
    sampleIdx = halfIdx[1:0] - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
      wordIdx  <= '0;
      chanCnt  <= '0;
      chipCnt  <= '0;
      laneDone <= 1'b0;
      timeReg  <= '0;
    end else if (trainStart) begin
      bitCnt   <= '0;
      wordIdx  <= '0;
      chanCnt  <= '0;
      chipCnt  <= '0;
      laneDone <= 1'b0;
    end else if (serStrobe && !laneDone) begin
      if (wordDone) begin
        bitCnt <= '0;
        if (isTime) timeReg <= word;
        if (wordIdx == 4'(WORDS_PER_CH - 1)) begin
          wordIdx <= '0;
          if (chanCnt == 10'(NUM_CHANNELS - 1)) begin
            chanCnt <= '0;
            if (chipCnt == 4'(NUM_CHIPS - 1)) laneDone <= 1'b1;
            else                              chipCnt  <= chipCnt + 4'd1;
          end else begin
            chanCnt <= chanCnt + 10'd1;
          end
        end else begin
          wordIdx <= wordIdx + 4'd1;
        end
      end else begin
        shiftReg <= {shiftReg[WORD_W-3:0], serBit};
        bitCnt   <= bitCnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendRec   <= '0;
    end else if (hitNow) begin
      pendValid          <= 1'b1;
      pendRec.trainLow   <= trainLow;
      pendRec.lane       <= LANE_ID;
      pendRec.chip       <= chipCnt;
      pendRec.chan       <= chanCnt;
      pendRec.sample     <= sampleIdx;
      pendRec.sampleTime <= 16'(timeReg);
      pendRec.adc        <= 16'(word);
    end else if (grant) begin
      pendValid <= 1'b0;
    end
  end

  // R7: a served record leaves the hold slot before the next one can enter
  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !hitNow) |=> !pendValid);
endmodule

// File: rtl/hcControl.sv
module hcControl
  import hcPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] pendVec,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic             outReady,
  output ctrlStrobe_t      strb
);
  logic [LANE_W-1:0] rrPtr;
  logic [LANE_W-1:0] grantIdx;
  logic [LANE_W-1:0] idx;
  logic [LANES-1:0]  grantVec;
  logic              found;
  logic [2:0]        byteIdx;

  always_comb begin
    grantVec = '0;
    found    = 1'b0;
    grantIdx = rrPtr;
    idx      = rrPtr;
    for (int i = 0; i < LANES; i++) begin
      idx = rrPtr + LANE_W'(i);
      if (!found && pendVec[idx]) begin
        found         = 1'b1;
        grantIdx      = idx;
        grantVec[idx] = 1'b1;
      end
    end
  end

  always_comb begin
    strb.grant   = grantVec;
    strb.push    = found && !fifoFull;
    strb.drop    = found && fifoFull;
    strb.pop     = !fifoEmpty && outReady && (byteIdx == 3'(BYTES_PER_REC - 1));
    strb.byteIdx = byteIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr   <= '0;
      byteIdx <= '0;
    end else begin
      if (found) rrPtr <= grantIdx + LANE_W'(1);
      if (!fifoEmpty && outReady) byteIdx <= byteIdx + 3'd1;
    end
  end

  // R8: at most one lane is served in any cycle
  p_grant_onehot_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec));
  // R8: only a lane holding a record is ever served
  p_grant_pending_r8: assert property (@(posedge clk) disable iff (!rstN)
    found |-> ((grantVec & pendVec) != '0));
endmodule

// File: rtl/hcDatapath.sv
module hcDatapath
  import hcPkg::*;
#(
  parameter int NUM_CHIPS    = 12,
  parameter int NUM_CHANNELS = 1024,
  parameter int FIFO_DEPTH   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  threshold,
  input  logic               trainStart,
  input  logic [15:0]        trainNum,
  input  logic [LANES-1:0]   serBit,
  input  logic [LANES-1:0]   serStrobe,
  input  ctrlStrobe_t        strb,
  output logic [LANES-1:0]   pendVec,
  output logic               fifoFull,
  output logic               fifoEmpty,
  output logic [7:0]         outData,
  output logic               overflow,
  output logic [15:0]        lostCount
);
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic [TRAIN_W-1:0] trainLatch;
  hitRec_t            laneRec [LANES];
  hitRec_t            selRec;
  hitRec_t            fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;
  logic [63:0]        headBits;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    hcLaneFront #(
      .NUM_CHIPS   (NUM_CHIPS),
      .NUM_CHANNELS(NUM_CHANNELS),
      .LANE_ID     (LANE_W'(g))
    ) uLane (
      .clk       (clk),
      .rstN      (rstN),
      .serBit    (serBit[g]),
      .serStrobe (serStrobe[g]),
      .trainStart(trainStart),
      .trainLow  (trainLatch),
      .threshold (threshold),
      .grant     (strb.grant[g]),
      .pendValid (pendVec[g]),
      .pendRec   (laneRec[g])
    );
  end

  always_comb begin
    selRec = '0;
    for (int i = 0; i < LANES; i++)
      if (strb.grant[i]) selRec = selRec | laneRec[i];
  end

  always_comb begin
    fifoFull  = (count == CNT_W'(FIFO_DEPTH));
    fifoEmpty = (count == '0);
    headBits  = fifoMem[rdPtr];
    outData   = headBits[{3'd7 - strb.byteIdx, 3'b000} +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) trainLatch <= '0;
    else if (trainStart) trainLatch <= trainNum[TRAIN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strb.push) fifoMem[wrPtr] <= selRec;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      overflow  <= 1'b0;
      lostCount <= '0;
    end else begin
      if (strb.push)
        wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + PTR_W'(1);
      if (strb.pop)
        rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + PTR_W'(1);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
      if (strb.drop) begin
        overflow <= 1'b1;
        if (lostCount != 16'hFFFF) lostCount <= lostCount + 16'd1;
      end
    end
  end

  // R9: occupancy never exceeds the FIFO depth
  p_fifo_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(FIFO_DEPTH));
  // R9: the loss counter only moves once the overflow flag is up
  p_lost_flagged_r9: assert property (@(posedge clk) disable iff (!rstN)
    (lostCount != $past(lostCount)) |-> overflow);
  // R9: a full FIFO without a pop stays full
  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !strb.pop) |=> fifoFull);
endmodule

// File: rtl/hitConcentrator.sv
module hitConcentrator
  import hcPkg::*;
#(
  parameter int NUM_CHIPS    = 12,
  parameter int NUM_CHANNELS = 1024,
  parameter int FIFO_DEPTH   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [12:0] threshold,
  input  logic        trainStart,
  input  logic [15:0] trainNum,
  input  logic [7:0]  serBit,
  input  logic [7:0]  serStrobe,
  output logic [7:0]  outData,
  output logic        outValid,
  input  logic        outReady,
  output logic        overflow,
  output logic [15:0] lostCount
);
  ctrlStrobe_t      strb;
  logic [LANES-1:0] pendVec;
  logic             fifoFull, fifoEmpty;

  hcControl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .pendVec  (pendVec),
    .fifoFull (fifoFull),
    .fifoEmpty(fifoEmpty),
    .outReady (outReady),
    .strb     (strb)
  );

  hcDatapath #(
    .NUM_CHIPS   (NUM_CHIPS),
    .NUM_CHANNELS(NUM_CHANNELS),
    .FIFO_DEPTH  (FIFO_DEPTH)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .threshold (threshold),
    .trainStart(trainStart),
    .trainNum  (trainNum),
    .serBit    (serBit),
    .serStrobe (serStrobe),
    .strb      (strb),
    .pendVec   (pendVec),
    .fifoFull  (fifoFull),
    .fifoEmpty (fifoEmpty),
    .outData   (outData),
    .overflow  (overflow),
    .lostCount (lostCount)
  );

  assign outValid = !fifoEmpty;

  // R6: a stalled byte is held
  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
  // R9: the overflow flag never falls outside reset
  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
endmodule

// File: tb/test_hitConcentrator.sv
module test_hitConcentrator;
  localparam int CHIPS = 2;
  localparam int CHANS = 3;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] threshold = '0;
  logic        trainStart = 1'b0;
  logic [15:0] trainNum = '0;
  logic [7:0]  serBit = '0;
  logic [7:0]  serStrobe = '0;
  logic [7:0]  outData;
  logic        outValid;
  logic        outReady = 1'b0;
  logic        overflow;
  logic [15:0] lostCount;

  hitConcentrator #(.NUM_CHIPS(CHIPS), .NUM_CHANNELS(CHANS), .FIFO_DEPTH(DEPTH)) i_hitConcentrator (
    .clk(clk), .rstN(rstN), .threshold(threshold), .trainStart(trainStart),
    .trainNum(trainNum), .serBit(serBit), .serStrobe(serStrobe), .outData(outData),
    .outValid(outValid), .outReady(outReady), .overflow(overflow), .lostCount(lostCount)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int rxMode  = 0;
  int rxTotal = 0;
  int hitTotal = 0;
  logic [63:0] expRec [8][64];
  int wrP [8];
  int rdP [8];
  logic [12:0] laneWord [8];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int ampOf(int l, int c, int ch, int s, int thr, int mode);
    int v;
    case ((l + c * 3 + ch * 5 + s + mode) % 6)
      0: v = 0;
      1: v = thr - 1;
      2: v = thr;
      3: v = thr + 1;
      4: v = 8191;
      default: v = thr + (l * 13 + ch * 3 + s + 1) * 17;
    endcase
    if (v < 0) v = 0;
    if (v > 8191) v = 8191;
    return v;
  endfunction

  // Receiver: decides ready at each falling edge, captures the byte taken at the next rising edge
  initial begin
    logic [63:0] acc = '0;
    int nb = 0;
    int cyc = 0;
    logic prevStall = 1'b0;
    logic [7:0] prevData = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (prevStall) begin
        // R6
        check(outValid === 1'b1, "R6", "valid dropped while stalled", {63'd0, outValid}, 64'd1);
        check(outData === prevData, "R6", "data moved while stalled", {56'd0, outData}, {56'd0, prevData});
      end
      outReady = (rxMode == 1) && ((cyc % 8) != 3);
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (outValid && outReady) begin
        acc = {acc[55:0], outData};
        nb++;
        if (nb == 8) begin
          int l;
          nb = 0;
          rxTotal++;
          l = int'(acc[50:48]);
          if (rdP[l] >= wrP[l]) begin
            check(1'b0, "R8", "unexpected record", acc, 64'd0);
          end else begin
            // R4 R5 R7: field layout, byte order and per-lane order
            check(acc === expRec[l][rdP[l]], "R4 R5 R7", "record mismatch", acc, expRec[l][rdP[l]]);
            rdP[l]++;
          end
        end
      end
    end
  end

  task automatic sendWords();
    for (int b = 12; b >= 0; b--) begin
      @(negedge clk);
      for (int l = 0; l < 8; l++) serBit[l] = laneWord[l][b];
      serStrobe = 8'hFF;
      @(negedge clk);
      serStrobe = 8'h00;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic runTrain(input logic [15:0] tr, input int thr, input int mode);
    for (int l = 0; l < 8; l++) begin wrP[l] = 0; rdP[l] = 0; end
    hitTotal = 0;
    @(negedge clk);
    threshold = 13'(thr);
    trainNum = tr;
    trainStart = 1'b1;
    @(negedge clk);
    trainStart = 1'b0;
    for (int c = 0; c < CHIPS; c++)
      for (int ch = 0; ch < CHANS; ch++) begin
        for (int l = 0; l < 8; l++) laneWord[l] = 13'((c * 977 + ch * 131 + l * 29 + 4321 + mode * 55) & 8191);
        sendWords();
        for (int s = 0; s < 4; s++) begin
          int tv [8];
          for (int l = 0; l < 8; l++) begin
            tv[l] = (l * 97 + c * 31 + ch * 7 + s * 3 + int'(tr) * 11) & 8191;
            laneWord[l] = 13'(tv[l]);
          end
          sendWords();
          for (int l = 0; l < 8; l++) begin
            int a;
            a = ampOf(l, c, ch, s, thr, mode);
            laneWord[l] = 13'(a);
            if (a > thr) begin
              expRec[l][wrP[l]] = {tr[12:0], 3'(l), 4'(c), 10'(ch), 2'(s), 3'b0, 13'(tv[l]), 3'b0, 13'(a)};
              wrP[l]++;
              hitTotal++;
            end
          end
          sendWords();
        end
      end
  endtask

  task automatic drainAndCheck(input string tag);
    int waitCyc = 0;
    bit done = 0;
    while (!done && waitCyc < 3000) begin
      @(negedge clk);
      waitCyc++;
      done = 1;
      for (int l = 0; l < 8; l++) if (rdP[l] != wrP[l]) done = 0;
    end
    repeat (40) @(negedge clk);
    for (int l = 0; l < 8; l++)
      check(rdP[l] == wrP[l], "R8", {tag, " per-lane record count"}, 64'(rdP[l]), 64'(wrP[l]));
    check(outValid == 1'b0, "R8", {tag, " no trailing record"}, {63'd0, outValid}, 64'd0);
    check(overflow == 1'b0, "R9", {tag, " no overflow at normal rate"}, {63'd0, overflow}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int l = 0; l < 8; l++) begin wrP[l] = 0; rdP[l] = 0; laneWord[l] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10
    check(outValid == 1'b0, "R10", "outValid after reset", {63'd0, outValid}, 64'd0);
    check(overflow == 1'b0, "R10", "overflow after reset", {63'd0, overflow}, 64'd0);
    check(lostCount == 16'd0, "R10", "lostCount after reset", 64'(lostCount), 64'd0);
    rxMode = 1;

    // Train A: mid threshold, boundary amplitudes (R1 R3)
    runTrain(16'h0123, 100, 0);
    // R2: words after the last chip are ignored
    for (int l = 0; l < 8; l++) laneWord[l] = 13'h1FFF;
    for (int w = 0; w < 9; w++) sendWords();
    check(hitTotal > 0, "R3", "train A has hits", 64'(hitTotal), 64'd1);
    drainAndCheck("R1 R2 R3 train A");

    // Train B: zero threshold, upper train bits set (R3 R4)
    rxTotal = 0;
    runTrain(16'hFFFF, 0, 1);
    drainAndCheck("R3 R4 train B");
    check(rxTotal == hitTotal, "R8", "train B total", 64'(rxTotal), 64'(hitTotal));

    // Train C: full-scale threshold, nothing kept (R3)
    rxTotal = 0;
    runTrain(16'h2000, 8191, 2);
    drainAndCheck("R3 train C");
    check(rxTotal == 0, "R3", "train C emits nothing", 64'(rxTotal), 64'd0);

    // Train D: output stalled, FIFO overflows (R9)
    rxMode = 0;
    rxTotal = 0;
    runTrain(16'h0042, 0, 3);
    repeat (20) @(negedge clk);
    check(overflow == 1'b1, "R9", "overflow set", {63'd0, overflow}, 64'd1);
    check(int'(lostCount) == hitTotal - DEPTH, "R9", "lost count", 64'(lostCount), 64'(hitTotal - DEPTH));
    rxMode = 1;
    repeat (300) @(negedge clk);
    check(rxTotal == DEPTH, "R9", "stored records delivered", 64'(rxTotal), 64'(DEPTH));
    check(outValid == 1'b0, "R9", "FIFO empty after drain", {63'd0, outValid}, 64'd0);
    check(overflow == 1'b1, "R9", "overflow sticky", {63'd0, overflow}, 64'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule